// File: doc/BRIEF.md
# Register-List Stack Transfer Engine

This block moves general registers between a register file and a stack in memory that grows toward lower addresses. One command moves either a single register (a push or a pop, at word or longword size) or a list of consecutive registers (a store or a load, always at longword size). For each command the engine produces the memory transfers and the register-file writes, and it updates the stack pointer.

The register file has eight 32-bit registers, and register 7 is the stack pointer. The engine samples the stack pointer on `sp_in` when it accepts a command and keeps a private copy while the command runs. Each time a transfer completes, it writes the updated copy back through `sp_we`/`sp_wdata`.

The memory port uses byte addresses and big-endian byte order. The data travels right-justified on the bus, and `mem_be` gives the size of each access. Each access waits for `mem_ready`. A command that cannot be carried out is refused with a one-cycle error pulse, and the memory port and the registers are left untouched.

Top module: `stack_xfer_engine`

## Requirements
- R1: A push (op 0) first lowers the stack pointer by the operand size and then writes the register at the new stack-pointer address. A store-list (op 2) does the same for each register in turn. The final stack pointer is written back to register 7.
- R2: A pop (op 1) reads at the current stack-pointer address into the register and then raises the stack pointer by the operand size.
- R3: A single push or pop is a word when `size_long`=0 and a longword when it is 1. A word uses a step of 2, `mem_be`=4'b0011, and only the low 16 bits of the register. A word pop writes only the low half (`rf_wmask`=2'b01) and keeps the upper half. A longword uses a step of 4, `mem_be`=4'b1111 and `rf_wmask`=2'b11.
- R4: A list command (op 2 store, op 3 load) covers the registers `reg_idx` to `reg_idx+reg_cnt-1` and always uses longword size, whatever `size_long` says. A store writes the highest register first. A load reads in ascending order. After either command, register `reg_idx+j` sits at the final-or-initial stack pointer plus 4*j, so a load undoes a store.
- R5: The engine holds `mem_req`, `mem_addr` and `mem_we` steady until `mem_ready` is seen. Each transfer therefore takes exactly one cycle more than the number of wait cycles.
- R6: `busy` goes high in the cycle after an accepted start. It stays high until the last transfer completes. `done` is high for exactly the one cycle that follows.
- R7: A list command is rejected if its count is below 2, its count is above 4, or its list reaches register 7. The rejection is an `err` pulse in the cycle after the start, with no memory access, no register write, and neither `busy` nor `done`.
- R8: A command is also rejected in the same way if the stack pointer is odd, or if it is a single push or pop of register 7. Every memory address the engine issues is even.
- R9: While reset is active, and after it is released, `busy`, `done`, `err`, `mem_req`, `rf_we` and `sp_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted while idle |
| op | input | 2 | 0 push, 1 pop, 2 store list, 3 load list |
| size_long | input | 1 | Single push/pop size: 1 longword, 0 word |
| reg_idx | input | 3 | Register, or first register of the list |
| reg_cnt | input | 3 | Number of registers in the list |
| sp_in | input | 32 | Current value of register 7 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Access size: 4'b1111 longword, 4'b0011 word |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ready | input | 1 | Access completes in this cycle |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wmask | output | 2 | Half-word write enables {upper, lower} |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | 32 | New stack-pointer value |

## Verification
A rejection shows on `err` in the cycle right after the start edge. An accepted command shows `busy` in that same cycle. `busy` then lasts n*(w+1) cycles for n transfers with w wait cycles, and `done` follows in the very next cycle. The bench drives inputs and samples outputs on falling edges. It counts the falling edges on which `busy` is high and compares that count with n*(w+1), then checks `done` on the next falling edge and checks that `done` is gone one edge later. Register and memory contents are compared once `done` has been seen, against values the bench works out from the starting stack pointer by address arithmetic.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {
    OP_PUSH       = 2'd0,
    OP_POP        = 2'd1,
    OP_STORE_LIST = 2'd2,
    OP_LOAD_LIST  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } stk_state_e;

  // bytes moved per transfer
  function automatic logic [AW-1:0] stk_step(input logic is_long);
    return is_long ? AW'(4) : AW'(2);
  endfunction

  // keep the whole word, or only its low half zero-extended
  function automatic logic [DW-1:0] stk_narrow(input logic is_long, input logic [DW-1:0] v);
    return is_long ? v : {{HW{1'b0}}, v[HW-1:0]};
  endfunction
endpackage

// File: rtl/stk_legal.sv
module stk_legal #(
  parameter int REG_N    = 8,
  parameter int MAX_LIST = 4,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 3
) (
  input  logic             is_list,
  input  logic [IDX_W-1:0] first,
  input  logic [CNT_W-1:0] count,
  input  logic             sp_odd,
  output logic             reject
);
  localparam int SW = IDX_W + CNT_W;
  localparam logic [SW-1:0]    END_LIM = SW'(REG_N);
  localparam logic [IDX_W-1:0] SP_IDX  = IDX_W'(REG_N - 1);

  logic [SW-1:0] end_x;
  logic          list_bad;
  logic          single_bad;

  always_comb begin
    end_x      = SW'(first) + SW'(count);
    list_bad   = (count < CNT_W'(2)) || (count > CNT_W'(MAX_LIST)) || (end_x >= END_LIM);
    single_bad = (first == SP_IDX);
    reject     = sp_odd || (is_list ? list_bad : single_bad);
  end
endmodule

// File: rtl/stk_addr_unit.sv
module stk_addr_unit
  import stk_pkg::*;
(
  input  logic [AW-1:0] sp,
  input  logic          is_push,
  input  logic          is_long,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] sp_next
);
  logic [AW-1:0] step;
  logic [AW-1:0] lowered;

  always_comb begin
    step    = stk_step(is_long);
    lowered = sp - step;
    addr    = is_push ? lowered : sp;
    sp_next = is_push ? lowered : sp + step;
  end
endmodule

// File: rtl/stack_xfer_engine.sv
module stack_xfer_engine
  import stk_pkg::*;
#(
  parameter int REG_N    = 8,
  parameter int MAX_LIST = 4,
  localparam int IDX_W   = $clog2(REG_N),
  localparam int CNT_W   = $clog2(REG_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic             size_long,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [CNT_W-1:0] reg_cnt,
  input  logic [AW-1:0]    sp_in,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [3:0]       mem_be,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  output logic [IDX_W-1:0] rf_raddr,
  input  logic [DW-1:0]    rf_rdata,
  output logic             rf_we,
  output logic [1:0]       rf_wmask,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             sp_we,
  output logic [AW-1:0]    sp_wdata
);
  stk_state_e       state_q;
  logic [AW-1:0]    sp_q;
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] rem_q;
  logic             is_push_q;
  logic             long_q;
  logic             down_q;
  logic             err_q;

  // named internal events
  logic          cmd_take;
  logic          cmd_illegal;
  logic          xfer_fire;
  logic          last_xfer;
  logic [AW-1:0] acc_addr;
  logic [AW-1:0] sp_after;
  stk_op_e       op_e;

  assign op_e      = stk_op_e'(op);
  assign cmd_take  = start && (state_q == ST_IDLE);
  assign xfer_fire = (state_q == ST_XFER) && mem_ready;
  assign last_xfer = xfer_fire && (rem_q == CNT_W'(1));

  stk_legal #(
    .REG_N(REG_N), .MAX_LIST(MAX_LIST), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_legal (
    .is_list(op[1]),
    .first  (reg_idx),
    .count  (reg_cnt),
    .sp_odd (sp_in[0]),
    .reject (cmd_illegal)
  );

  stk_addr_unit u_addr (
    .sp     (sp_q),
    .is_push(is_push_q),
    .is_long(long_q),
    .addr   (acc_addr),
    .sp_next(sp_after)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sp_q      <= '0;
      cur_q     <= '0;
      rem_q     <= '0;
      is_push_q <= 1'b0;
      long_q    <= 1'b0;
      down_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_take) begin
            if (cmd_illegal) begin
              err_q <= 1'b1;
            end else begin
              state_q   <= ST_XFER;
              sp_q      <= sp_in;
              is_push_q <= ~op[0];
              long_q    <= op[1] | size_long;
              rem_q     <= op[1] ? reg_cnt : CNT_W'(1);
              down_q    <= (op_e == OP_STORE_LIST);
              cur_q     <= (op_e == OP_STORE_LIST)
                           ? reg_idx + IDX_W'(reg_cnt) - IDX_W'(1)
                           : reg_idx;
            end
          end
        end
        ST_XFER: begin
          if (xfer_fire) begin
            sp_q  <= sp_after;
            rem_q <= rem_q - CNT_W'(1);
            cur_q <= down_q ? cur_q - IDX_W'(1) : cur_q + IDX_W'(1);
            if (last_xfer) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == ST_XFER);
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;

  assign mem_req   = busy;
  assign mem_we    = busy && is_push_q;
  assign mem_addr  = acc_addr;
  assign mem_be    = long_q ? 4'b1111 : 4'b0011;
  assign mem_wdata = stk_narrow(long_q, rf_rdata);

  assign rf_raddr  = cur_q;
  assign rf_we     = xfer_fire && !is_push_q;
  assign rf_waddr  = cur_q;
  assign rf_wmask  = long_q ? 2'b11 : 2'b01;
  assign rf_wdata  = stk_narrow(long_q, mem_rdata);

  assign sp_we     = xfer_fire;
  assign sp_wdata  = sp_after;
endmodule

// File: rtl/stk_xfer_chk.sv
module stk_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        mem_ready,
  input logic        sp_we,
  input logic [31:0] sp_wdata,
  input logic        last_xfer
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R6
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> (done && !busy));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_req && !busy && !done));

  // R8
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  // R8
  even_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> !sp_wdata[0]);

  // R3
  lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'b1111 || mem_be == 4'b0011));
endmodule

bind stack_xfer_engine stk_xfer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_ready(mem_ready),
  .sp_we    (sp_we),
  .sp_wdata (sp_wdata),
  .last_xfer(last_xfer)
);

// File: tb/tb_stack_xfer_engine.sv
module tb_stack_xfer_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        size_long = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [2:0]  reg_cnt = 3'd0;
  logic [31:0] sp_in;
  logic        busy, done, err, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, sp_wdata;
  logic        rf_we, sp_we;
  logic [1:0]  rf_wmask;

  logic [31:0] regs [8];
  logic [7:0]  mem  [256];
  logic [31:0] exp_regs [8];
  logic [7:0]  exp_mem  [256];
  logic [3:0]  wcnt;
  logic [3:0]  wait_n = 4'd0;
  logic [7:0]  ra;
  int          acc_cnt = 0;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  stack_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size_long(size_long),
    .reg_idx(reg_idx), .reg_cnt(reg_cnt), .sp_in(sp_in),
    .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wmask(rf_wmask),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata)
  );

  assign rf_rdata  = regs[rf_raddr];
  assign sp_in     = regs[7];
  assign mem_ready = mem_req && (wcnt == wait_n);

  always_comb begin
    ra = mem_addr[7:0];
    if (mem_be == 4'b1111)
      mem_rdata = {mem[ra], mem[ra + 8'd1], mem[ra + 8'd2], mem[ra + 8'd3]};
    else
      mem_rdata = {16'hA5A5, mem[ra], mem[ra + 8'd1]};
  end

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 4'd1;
    else wcnt <= 4'd0;
    if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        if (mem_be == 4'b1111) begin
          mem[ra]        <= mem_wdata[31:24];
          mem[ra + 8'd1] <= mem_wdata[23:16];
          mem[ra + 8'd2] <= mem_wdata[15:8];
          mem[ra + 8'd3] <= mem_wdata[7:0];
        end else begin
          mem[ra]        <= mem_wdata[15:8];
          mem[ra + 8'd1] <= mem_wdata[7:0];
        end
      end
    end
    if (rf_we) begin
      if (rf_wmask[1]) regs[rf_waddr][31:16] <= rf_wdata[31:16];
      if (rf_wmask[0]) regs[rf_waddr][15:0]  <= rf_wdata[15:0];
    end
    if (sp_we) regs[7] <= sp_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic setup(input int seed, input logic [31:0] sp);
    for (int i = 0; i < 7; i++)
      regs[i] = ((32'(i) + 32'd1) * 32'h0101_0101) ^ (32'(seed) * 32'h9E37_79B9);
    regs[7] = sp;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + seed);
  endtask

  task automatic compare_state(input string tag);
    int diffs = 0;
    for (int i = 0; i < 8; i++) chk(tag, regs[i], exp_regs[i]);
    for (int k = 0; k < 256; k++) if (mem[k] !== exp_mem[k]) diffs++;
    chk(tag, 32'(diffs), 32'd0);
  endtask

  task automatic issue(input logic [1:0] o, input logic lg, input logic [2:0] s, input logic [2:0] n);
    logic [31:0] sp0, base, val;
    logic        is_list, bad;
    int          cnt, sz, cyc, acc0, r;
    string       tag;
    for (int i = 0; i < 8; i++) exp_regs[i] = regs[i];
    for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
    sp0     = regs[7];
    is_list = o[1];
    cnt     = is_list ? int'(n) : 1;
    sz      = (is_list || lg) ? 4 : 2;
    bad     = sp0[0] || (is_list ? (n < 3'd2 || n > 3'd4 || int'(s) + int'(n) > 7) : (s == 3'd7));
    tag     = is_list ? "R4" : (!lg ? "R3" : (o[0] ? "R2" : "R1"));
    if (!bad) begin
      if (!o[0]) begin
        base = sp0 - 32'(cnt * sz);
        for (int j = 0; j < cnt; j++) begin
          r = int'(s) + j;
          for (int b = 0; b < sz; b++)
            exp_mem[8'(base + 32'(j * sz + b))] = 8'(regs[r] >> (8 * (sz - 1 - b)));
        end
        exp_regs[7] = base;
      end else begin
        for (int j = 0; j < cnt; j++) begin
          r = int'(s) + j;
          val = '0;
          for (int b = 0; b < sz; b++)
            val = (val << 8) | 32'(mem[8'(sp0 + 32'(j * sz + b))]);
          if (sz == 4) exp_regs[r] = val;
          else exp_regs[r][15:0] = val[15:0];
        end
        exp_regs[7] = sp0 + 32'(cnt * sz);
      end
    end
    acc0 = acc_cnt;
    @(negedge clk);
    start = 1'b1; op = o; size_long = lg; reg_idx = s; reg_cnt = n;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      chk(sp0[0] || !is_list ? "R8" : "R7", 32'(err), 32'd1);
      chk("R7", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R7", 32'(err | busy | done), 32'd0);
      @(negedge clk);
      chk("R7", 32'(acc_cnt - acc0), 32'd0);
      compare_state("R7");
    end else begin
      chk("R6", 32'(busy), 32'd1);
      chk("R6", 32'(err), 32'd0);
      cyc = 0;
      while (busy && cyc < 200) begin
        cyc++;
        @(negedge clk);
      end
      chk("R5", 32'(cyc), 32'(cnt * (int'(wait_n) + 1)));
      chk("R6", 32'(done), 32'd1);
      @(negedge clk);
      chk("R6", 32'(done), 32'd0);
      chk(tag, 32'(acc_cnt - acc0), 32'(cnt));
      compare_state(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] saved [8];
    setup(1, 32'h80);
    repeat (3) @(negedge clk);
    // R9 during reset
    chk("R9", 32'({busy, done, err, mem_req, rf_we, sp_we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", 32'({busy, done, err, mem_req, rf_we, sp_we}), 32'd0);

    // single push/pop sweep: R1 R2 R3 R8 (reg 7)
    for (int w = 0; w < 3; w++)
      for (int o = 0; o < 2; o++)
        for (int lg = 0; lg < 2; lg++)
          for (int s = 0; s < 8; s++) begin
            wait_n = 4'(w);
            setup(w * 64 + o * 16 + lg * 8 + s, 32'h80 + 32'(2 * s));
            issue(2'(o), 1'(lg), 3'(s), 3'd0);
          end

    // list sweep over all starts and counts: R4 R7, size input ignored
    for (int o = 2; o < 4; o++)
      for (int s = 0; s < 8; s++)
        for (int n = 0; n < 8; n++) begin
          wait_n = 4'((s + n) % 3);
          setup(o * 64 + s * 8 + n, 32'h90 - 32'(4 * n));
          issue(2'(o), 1'(n & 1), 3'(s), 3'(n));
        end

    // odd stack pointer: R8
    wait_n = 4'd1;
    for (int o = 0; o < 4; o++) begin
      setup(300 + o, 32'h81);
      issue(2'(o), 1'b1, 3'd1, 3'd3);
    end

    // store then load restores the list: R4
    wait_n = 4'd2;
    setup(400, 32'hA0);
    for (int i = 0; i < 8; i++) saved[i] = regs[i];
    issue(2'd2, 1'b0, 3'd1, 3'd4);
    @(negedge clk);
    for (int i = 1; i < 5; i++) regs[i] = 32'h0;
    issue(2'd3, 1'b0, 3'd1, 3'd4);
    for (int i = 0; i < 8; i++) chk("R4", regs[i], saved[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule